// File: doc/BRIEF.md
# Time Slot Assigner Memory Init Sequencer

This block controls a small time-slot assigner memory. It has one entry per time slot, and each entry is a 16-bit word. A processor reaches the memory through two registers. The command register carries a slot number, a read/write select and an init flag. The data register holds the word that is to be stored. Every word written to the command register arrives as a valid/ready transfer. Read results leave the block on a valid/ready output stream. The data register is loaded by a plain write strobe.

While the init flag is set, the block does two things:
- A fill sequencer visits one entry per clock cycle, from slot 0 up to the last slot and then back to 0. Each entry it visits receives the data register, except that the channel field is replaced by the entry's own slot number.
- Five reset outputs stay asserted. They drive the transmit and receive HDLC controllers, the transmit and receive DMA engines, and the GCI controller.

The init flag is set by a pin reset or by the software reset input. It stays set until the processor writes a command with init cleared. From then on, each command reads or writes a single entry.

Back-pressure works as follows. A read result is held on `rd_data` with `rd_valid` high until the consumer raises `rd_ready`. While a result is waiting, `cmd_ready` is low, so no new command of either kind is accepted. When `rd_ready` is high in the same cycle, a new command may be accepted while the old result is handed over.

Top module: `tsa_init_ctrl`

## Requirements
- R1: The command word has these fields: bits [15:11] hold the slot number, bit 10 is the read select (1 = read, 0 = write), and bit 8 is the init flag. After pin reset, the command register holds 0x0100, so init is active.
- R2: The five controller reset outputs (active high) are 1 from reset. They are 1 again in the cycle after a command with init = 1 is accepted, and in the cycle after `soft_rst`. They are 0 from the cycle after a command with init = 0 is accepted.
- R3: While init is active, the sequencer writes one entry per clock and wraps from slot 31 to slot 0. Each entry it writes receives the data register with bits [4:0] replaced by the entry's slot number. Within 32 cycles every entry holds that image.
- R4: A command with init = 0 stops the sequencer in the cycle it is accepted. Later changes to the data register then leave the memory unchanged.
- R5: A command with read = 0 and init = 0 writes the whole 16-bit data register, channel bits included, into the selected slot.
- R6: A command with read = 0 and init = 1 writes no processor data into the memory.
- R7: A command with read = 1 returns the entry at the selected slot on `rd_data`, with `rd_valid` high in the cycle after the command is accepted. The init flag in the same command still takes effect.
- R8: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high, `rd_data` stays stable and `cmd_ready` is low.
- R9: `soft_rst` returns the command register to 0x0100 and restarts the sequencer at slot 0. It keeps the data register.
- R10: `dat_we` loads `dat_wdata` into the data register, which resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous pin reset, active low |
| soft_rst | input | 1 | Synchronous software reset, active high |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Command word accepted this cycle if valid |
| cmd_data | input | 16 | Command word (slot, read select, init flag) |
| dat_we | input | 1 | Data register write strobe |
| dat_wdata | input | 16 | Data register write value |
| rd_valid | output | 1 | Read result present |
| rd_ready | input | 1 | Consumer takes the read result |
| rd_data | output | 16 | Read result |
| tx_hdlc_rst | output | 1 | Transmit HDLC controller reset |
| rx_hdlc_rst | output | 1 | Receive HDLC controller reset |
| tx_dma_rst | output | 1 | Transmit DMA reset |
| rx_dma_rst | output | 1 | Receive DMA reset |
| gci_rst | output | 1 | GCI controller reset |

## Verification
The assertions check four things on every cycle:
- The processor and the sequencer never write the memory in the same cycle.
- Every sequencer write carries its own slot number in the channel bits.
- A stalled read result holds still.
- The reset outputs follow the init flag of each accepted command.

Only the bench scenarios can show the effects that span many cycles. These are that a full wrap leaves the whole memory holding the image, that a stopped sequencer no longer tracks data register changes, that write commands issued during init leave no trace, and that a software reset refills the memory.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int SLOT_W   = 5;
  localparam int NSLOT    = 1 << SLOT_W;
  localparam int WORD_W   = 16;
  localparam int SLOT_LSB = 11;
  localparam int RD_BIT   = 10;
  localparam int INIT_BIT = 8;
  localparam logic [WORD_W-1:0] CMD_RST = 16'h0100;

  typedef struct packed {
    logic [SLOT_W-1:0] slot;
    logic              rd;
    logic              init;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [WORD_W-1:0] w);
    cmd_t c;
    c.slot = w[SLOT_LSB +: SLOT_W];
    c.rd   = w[RD_BIT];
    c.init = w[INIT_BIT];
    return c;
  endfunction
endpackage

// File: rtl/tsa_cmd_regs.sv
module tsa_cmd_regs
  import tsa_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic                cmd_fire,
  input  logic [WORD_W-1:0]   cmd_data,
  input  logic                dat_we,
  input  logic [WORD_W-1:0]   dat_wdata,
  output logic                init_on,
  output logic                seq_run,
  output logic                cpu_we,
  output logic                rd_req,
  output logic [SLOT_W-1:0]   cpu_addr,
  output logic [WORD_W-1:0]   dreg
);
  logic [WORD_W-1:0] creg_q;
  cmd_t              cmd;

  always_comb cmd = decode_cmd(cmd_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      creg_q <= CMD_RST;
      dreg   <= '0;
    end else begin
      if (soft_rst)      creg_q <= CMD_RST;
      else if (cmd_fire) creg_q <= cmd_data;
      if (dat_we)        dreg   <= dat_wdata;
    end
  end

  always_comb begin
    init_on  = creg_q[INIT_BIT];
    seq_run  = init_on && !(cmd_fire && !cmd.init && !soft_rst);
    cpu_we   = cmd_fire && !soft_rst && !cmd.rd && !cmd.init;
    rd_req   = cmd_fire && cmd.rd;
    cpu_addr = cmd.slot;
  end

  assert_write_needs_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd.init) |-> !cpu_we);
endmodule

// File: rtl/tsa_fill_seq.sv
module tsa_fill_seq
  import tsa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              run,
  input  logic [WORD_W-1:0] dreg,
  output logic              seq_we,
  output logic [SLOT_W-1:0] seq_addr,
  output logic [WORD_W-1:0] seq_wdata
);
  logic [SLOT_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr_q <= '0;
    else if (soft_rst) ptr_q <= '0;
    else if (run)      ptr_q <= ptr_q + 1'b1;
  end

  always_comb begin
    seq_we    = run && !soft_rst;
    seq_addr  = ptr_q;
    seq_wdata = {dreg[WORD_W-1:SLOT_W], ptr_q};
  end
endmodule

// File: rtl/tsa_mem.sv
module tsa_mem
  import tsa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [SLOT_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  input  logic              seq_we,
  input  logic [SLOT_W-1:0] seq_addr,
  input  logic [WORD_W-1:0] seq_wdata,
  input  logic              rd_req,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_busy
);
  logic [WORD_W-1:0] row_q [NSLOT];
  logic              we;
  logic [SLOT_W-1:0] waddr;
  logic [WORD_W-1:0] wdata;

  always_comb begin
    we    = cpu_we || seq_we;
    waddr = cpu_we ? cpu_addr  : seq_addr;
    wdata = cpu_we ? cpu_wdata : seq_wdata;
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        row_q[i] <= '0;
      else if (we && waddr == SLOT_W'(i)) row_q[i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (rd_req) begin
      rd_valid <= 1'b1;
      rd_data  <= row_q[cpu_addr];
    end else if (rd_ready) begin
      rd_valid <= 1'b0;
    end
  end

  assign rd_busy = rd_valid && !rd_ready;

  assert_single_writer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_we && seq_we));
  assert_fill_channel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_we |-> (seq_wdata[SLOT_W-1:0] == seq_addr));
  assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: rtl/tsa_init_ctrl.sv
module tsa_init_ctrl
  import tsa_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [15:0] cmd_data,
  input  logic        dat_we,
  input  logic [15:0] dat_wdata,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic [15:0] rd_data,
  output logic        tx_hdlc_rst,
  output logic        rx_hdlc_rst,
  output logic        tx_dma_rst,
  output logic        rx_dma_rst,
  output logic        gci_rst
);
  logic              cmd_fire, init_on, seq_run, cpu_we, rd_req, rd_busy;
  logic              seq_we;
  logic [SLOT_W-1:0] cpu_addr, seq_addr;
  logic [WORD_W-1:0] dreg, seq_wdata;

  assign cmd_ready = !rd_busy;
  assign cmd_fire  = cmd_valid && cmd_ready;

  tsa_cmd_regs u_regs (
    .clk, .rst_n, .soft_rst, .cmd_fire, .cmd_data, .dat_we, .dat_wdata,
    .init_on, .seq_run, .cpu_we, .rd_req, .cpu_addr, .dreg
  );

  tsa_fill_seq u_seq (
    .clk, .rst_n, .soft_rst, .run(seq_run), .dreg,
    .seq_we, .seq_addr, .seq_wdata
  );

  tsa_mem u_mem (
    .clk, .rst_n, .cpu_we, .cpu_addr, .cpu_wdata(dreg),
    .seq_we, .seq_addr, .seq_wdata, .rd_req,
    .rd_valid, .rd_ready, .rd_data, .rd_busy
  );

  always_comb begin
    tx_hdlc_rst = init_on;
    rx_hdlc_rst = init_on;
    tx_dma_rst  = init_on;
    rx_dma_rst  = init_on;
    gci_rst     = init_on;
  end

  assert_rst_follows_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !soft_rst) |=> (gci_rst == $past(cmd_data[INIT_BIT])));
  assert_soft_rst_inits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (tx_hdlc_rst && rx_dma_rst));
  assert_busy_blocks_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |-> !cmd_ready);
endmodule

// File: tb/tsa_init_ctrl_tb.sv
module tsa_init_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_data = '0;
  logic        dat_we = 1'b0;
  logic [15:0] dat_wdata = '0;
  logic        rd_valid;
  logic        rd_ready = 1'b1;
  logic [15:0] rd_data;
  logic        tx_hdlc_rst, rx_hdlc_rst, tx_dma_rst, rx_dma_rst, gci_rst;

  int checks = 0;
  int fails = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tsa_init_ctrl u_dut (
    .clk, .rst_n, .soft_rst, .cmd_valid, .cmd_ready, .cmd_data,
    .dat_we, .dat_wdata, .rd_valid, .rd_ready, .rd_data,
    .tx_hdlc_rst, .rx_hdlc_rst, .tx_dma_rst, .rx_dma_rst, .gci_rst
  );

  function automatic logic [15:0] mk(input int slot, input bit rd, input bit init);
    return {slot[4:0], rd, 1'b0, init, 8'h00};
  endfunction

  function automatic logic [15:0] img(input logic [15:0] d, input int slot);
    return {d[15:5], slot[4:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_rst(input bit exp, input string tag);
    logic [4:0] v;
    v = {tx_hdlc_rst, rx_hdlc_rst, tx_dma_rst, rx_dma_rst, gci_rst};
    chk(v == {5{exp}}, tag, {11'd0, v}, {11'd0, {5{exp}}});
  endtask

  task automatic send_cmd(input logic [15:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = w;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic set_data(input logic [15:0] d);
    @(negedge clk);
    dat_we    = 1'b1;
    dat_wdata = d;
    @(negedge clk);
    dat_we    = 1'b0;
  endtask

  task automatic rd(input int slot, input bit init, input logic [15:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    send_cmd(mk(slot, 1'b1, init));
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // monitor: pops the scoreboard as each beat is handed over
  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected read beat", rd_data, 16'h0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rd_data == e, t, rd_data, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: R1 init set, R2 resets high
    chk_rst(1'b1, "R2 resets after pin reset");
    chk(rd_valid == 1'b0, "R7 no result after reset", {15'd0, rd_valid}, 16'h0);
    chk(cmd_ready == 1'b1, "R8 ready after reset", {15'd0, cmd_ready}, 16'h1);

    // R10 / R3: fill image from data register
    set_data(16'hABCD);
    repeat (40) @(negedge clk);
    rd(0, 1'b1, img(16'hABCD, 0), "R3 fill slot 0");
    rd(7, 1'b1, img(16'hABCD, 7), "R3 fill slot 7");
    rd(31, 1'b1, img(16'hABCD, 31), "R3 fill slot 31 R1");
    drain();
    chk_rst(1'b1, "R2 still in init after read with init=1");

    // R5 / R4: stop with a write
    send_cmd(mk(3, 1'b0, 1'b0));
    chk_rst(1'b0, "R2 resets drop after init=0");
    set_data(16'h1234);
    repeat (40) @(negedge clk);
    rd(3, 1'b0, 16'hABCD, "R5 full word write slot 3");
    rd(4, 1'b0, img(16'hABCD, 4), "R4 stopped sequencer keeps slot 4");
    drain();
    send_cmd(mk(4, 1'b0, 1'b0));
    rd(4, 1'b0, 16'h1234, "R5 normal write slot 4");
    drain();

    // R2 / R3: restart init
    send_cmd(mk(9, 1'b0, 1'b1));
    chk_rst(1'b1, "R2 resets rise on init=1");
    repeat (40) @(negedge clk);
    rd(9, 1'b1, img(16'h1234, 9), "R3 refill slot 9");
    rd(4, 1'b1, img(16'h1234, 4), "R3 refill slot 4");
    drain();

    // R6: processor writes ignored during init
    set_data(16'hFFFF);
    repeat (40) @(negedge clk);
    for (int s = 2; s < 12; s += 2) begin
      send_cmd(mk(s, 1'b0, 1'b1));
      rd(s, 1'b1, img(16'hFFFF, s), "R6 write ignored in init");
    end
    drain();

    // R9: soft reset refills
    send_cmd(mk(5, 1'b0, 1'b0));
    rd(5, 1'b0, 16'hFFFF, "R5 write slot 5 before soft reset");
    drain();
    set_data(16'h5555);
    chk_rst(1'b0, "R2 low before soft reset");
    @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk_rst(1'b1, "R9 soft reset restores init");
    repeat (40) @(negedge clk);
    rd(5, 1'b1, img(16'h5555, 5), "R9 refill after soft reset keeps data reg");
    drain();

    // R8: back-pressure
    rd_ready = 1'b0;
    exp_q.push_back(img(16'h5555, 20));
    tag_q.push_back("R8 stalled beat delivered");
    send_cmd(mk(20, 1'b1, 1'b1));
    begin
      logic [15:0] held;
      held = rd_data;
      chk(rd_valid == 1'b1, "R8 valid during stall", {15'd0, rd_valid}, 16'h1);
      chk(cmd_ready == 1'b0, "R8 cmd blocked during stall", {15'd0, cmd_ready}, 16'h0);
      repeat (3) @(negedge clk);
      chk(rd_valid == 1'b1, "R8 valid held", {15'd0, rd_valid}, 16'h1);
      chk(rd_data == held, "R8 data stable", rd_data, held);
    end
    rd_ready = 1'b1;
    drain();
    @(negedge clk);
    chk(rd_valid == 1'b0, "R8 valid drops after handover", {15'd0, rd_valid}, 16'h0);

    finish_up();
  end
endmodule